// File: doc/BRIEF.md
# Rotary Pulse Dialing Generator

This block turns digit codes into loop-disconnect pulse trains on a single dial-pulse line, in the way a mechanical rotary dial would. Each accepted digit becomes a pre-digit make interval, a counted run of break/make periods and a closing interdigit pause. A select input sets the rate to 10 or 20 pulses per second. A second select sets the make/break split to 40:60 or 33.3:66.7. Every duration is counted in whole ticks of a one-millisecond strobe that the block receives from outside.

Both selects are captured when a digit is accepted and hold until that digit's interdigit pause ends. The block takes one digit at a time. While busy it ignores new strobes, so the feeding logic waits for busy to drop before it offers the next digit. Two mute outputs frame the activity. The hold/pulse mute is high while pulses are being produced. The active-low tone/pulse mute is low for the whole sequence, interdigit pause included. Going on-hook stops everything at once and puts all outputs back at idle.

Top module: `pulse_dialer`

## Requirements
- R1: After reset, dp_o is 0, busy_o is 0, hp_mute_o is 0 and tp_mute_no is 1.
- R2: A strobe with code 1 to 9 produces that many break pulses, code 0 produces ten, and codes 10 to 15 are ignored (busy_o stays 0).
- R3: At 10 pulses per second with ratio_40_i=1, each break lasts 60 ticks and each make between breaks lasts 40 ticks.
- R4: At 10 pulses per second with ratio_40_i=0, each break lasts 67 ticks and each make lasts 33 ticks.
- R5: At 20 pulses per second (rate_20_i=1), break/make is 30/20 ticks with ratio_40_i=1 and 33/17 ticks with ratio_40_i=0.
- R6: Between acceptance and the first break there is a pre-digit pause equal to the make length of the selected rate and ratio.
- R7: After the last break there is an interdigit pause of 800 ticks at 10 pulses per second or 500 ticks at 20 pulses per second, and busy_o stays 1 until it ends.
- R8: A strobe that arrives while busy_o is 1 is ignored and produces no pulses.
- R9: hp_mute_o is 1 from acceptance until the last break ends, and 0 during the interdigit pause and while idle.
- R10: tp_mute_no is 0 while a digit is in progress (busy_o=1) and 1 otherwise.
- R11: on_hook_i=1 returns dp_o, busy_o and hp_mute_o to 0 and tp_mute_no to 1 on the next clock edge, drops the digit in progress, and blocks new strobes.
- R12: rate_20_i and ratio_40_i are sampled at acceptance, and changing them during a digit does not change that digit's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle strobe, once per millisecond |
| digit_valid_i | input | 1 | Digit strobe |
| digit_i | input | 4 | Digit code (0 means ten pulses) |
| rate_20_i | input | 1 | 1 = 20 pulses/s, 0 = 10 pulses/s |
| ratio_40_i | input | 1 | 1 = 40:60 make/break, 0 = 33.3:66.7 |
| on_hook_i | input | 1 | 1 = on-hook, aborts dialing |
| dp_o | output | 1 | Dial pulse, 1 during a break |
| busy_o | output | 1 | Digit in progress, strobes ignored |
| hp_mute_o | output | 1 | High while pulses are produced |
| tp_mute_no | output | 1 | Low for the whole dialing sequence |

## Verification
The case that is hardest to reach from the ports is a select change or a second strobe in the middle of a pulse train, where any slip in the latching or the acceptance gate would show only as a stretched period or an extra break several hundred ticks later. The stimulus starts a digit, waits for the first rising edge of dp_o, and then flips both selects or issues a second strobe. A scoreboard then compares every measured pause, break and make against the lengths predicted from the settings at acceptance. The on-hook abort is injected in the middle of a break, and a strobe is offered while on-hook to confirm that nothing starts.

// File: rtl/dial_pkg.sv
package dial_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_BREAK = 3'd2,
    ST_MAKE  = 3'd3,
    ST_IDP   = 3'd4
  } dial_state_e;

  // Break count for a digit code; 0 means the code is not dialable.
  function automatic logic [3:0] pulse_count(input logic [3:0] code);
    if (code == 4'd0)      pulse_count = 4'd10;
    else if (code <= 4'd9) pulse_count = code;
    else                   pulse_count = 4'd0;
  endfunction

endpackage

// File: rtl/dial_timing.sv
module dial_timing
  import dial_pkg::*;
#(
  parameter int TW        = 10,
  parameter int MK_10_40  = 40,
  parameter int BK_10_40  = 60,
  parameter int MK_10_33  = 33,
  parameter int BK_10_33  = 67,
  parameter int MK_20_40  = 20,
  parameter int BK_20_40  = 30,
  parameter int MK_20_33  = 17,
  parameter int BK_20_33  = 33,
  parameter int IDP_10    = 800,
  parameter int IDP_20    = 500
) (
  input  dial_state_e    state_i,
  input  logic           rate_20_i,
  input  logic           ratio_40_i,
  output logic [TW-1:0]  dur_o
);

  logic [TW-1:0] make_ms, break_ms, idp_ms;

  always_comb begin
    unique case ({rate_20_i, ratio_40_i})
      2'b00:   begin make_ms = TW'(MK_10_33); break_ms = TW'(BK_10_33); end
      2'b01:   begin make_ms = TW'(MK_10_40); break_ms = TW'(BK_10_40); end
      2'b10:   begin make_ms = TW'(MK_20_33); break_ms = TW'(BK_20_33); end
      default: begin make_ms = TW'(MK_20_40); break_ms = TW'(BK_20_40); end
    endcase
    idp_ms = rate_20_i ? TW'(IDP_20) : TW'(IDP_10);
  end

  always_comb begin
    unique case (state_i)
      ST_BREAK: dur_o = break_ms;
      ST_IDP:   dur_o = idp_ms;
      default:  dur_o = make_ms;
    endcase
  end

endmodule

// File: rtl/dial_timer.sv
module dial_timer #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [TW-1:0] dur_i,
  output logic          done_o
);

  logic [TW-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == dur_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // Phase counter never passes the length of the phase it times.
  assert_cnt_in_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < dur_i);

endmodule

// File: rtl/dial_fsm.sv
module dial_fsm
  import dial_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        digit_valid_i,
  input  logic [3:0]  digit_i,
  input  logic        rate_20_i,
  input  logic        ratio_40_i,
  input  logic        on_hook_i,
  input  logic        phase_done_i,
  output dial_state_e state_o,
  output logic        rate_q_o,
  output logic        ratio_q_o,
  output logic        phase_clr_o,
  output logic        dp_o,
  output logic        busy_o,
  output logic        hp_mute_o,
  output logic        tp_mute_no
);

  dial_state_e state_q, state_d;
  logic [3:0]  left_q, left_d;
  logic        rate_q, ratio_q;
  logic        accept;

  assign accept = (state_q == ST_IDLE) && digit_valid_i && !on_hook_i &&
                  (pulse_count(digit_i) != 4'd0);

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_PRE;
        left_d  = pulse_count(digit_i);
      end
      ST_PRE:  if (phase_done_i) state_d = ST_BREAK;
      ST_BREAK: if (phase_done_i) begin
        left_d  = left_q - 1'b1;
        state_d = (left_q == 4'd1) ? ST_IDP : ST_MAKE;
      end
      ST_MAKE: if (phase_done_i) state_d = ST_BREAK;
      ST_IDP:  if (phase_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (on_hook_i) begin
      state_d = ST_IDLE;
      left_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      rate_q  <= 1'b0;
      ratio_q <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      if (accept) begin
        rate_q  <= rate_20_i;
        ratio_q <= ratio_40_i;
      end
    end
  end

  assign phase_clr_o = (state_d != state_q) || (state_q == ST_IDLE);
  assign state_o     = state_q;
  assign rate_q_o    = rate_q;
  assign ratio_q_o   = ratio_q;
  assign dp_o        = (state_q == ST_BREAK);
  assign busy_o      = (state_q != ST_IDLE);
  assign hp_mute_o   = (state_q == ST_PRE) || (state_q == ST_BREAK) || (state_q == ST_MAKE);
  assign tp_mute_no  = (state_q == ST_IDLE);

  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_hook_i |=> (!dp_o && !busy_o));

  assert_count_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= 4'd10);

  assert_accept_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(digit_valid_i) && !$past(on_hook_i)));

  assert_latched_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(rate_q) && $stable(ratio_q)));

  assert_mute_then_idp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hp_mute_o) && !$past(on_hook_i)) |-> busy_o);

  assert_idp_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(on_hook_i)) |-> ($past(state_q) == ST_IDP));

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
  import dial_pkg::*;
#(
  parameter int MK_10_40 = 40,
  parameter int BK_10_40 = 60,
  parameter int MK_10_33 = 33,
  parameter int BK_10_33 = 67,
  parameter int MK_20_40 = 20,
  parameter int BK_20_40 = 30,
  parameter int MK_20_33 = 17,
  parameter int BK_20_33 = 33,
  parameter int IDP_10   = 800,
  parameter int IDP_20   = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_ms_i,
  input  logic       digit_valid_i,
  input  logic [3:0] digit_i,
  input  logic       rate_20_i,
  input  logic       ratio_40_i,
  input  logic       on_hook_i,
  output logic       dp_o,
  output logic       busy_o,
  output logic       hp_mute_o,
  output logic       tp_mute_no
);

  localparam int MAX_BK = (BK_10_33 > BK_10_40) ? BK_10_33 : BK_10_40;
  localparam int MAX_ID = (IDP_10 > IDP_20) ? IDP_10 : IDP_20;
  localparam int MAX_MS = (MAX_ID > MAX_BK) ? MAX_ID : MAX_BK;
  localparam int TW     = $clog2(MAX_MS + 1);

  dial_state_e   state;
  logic          rate_q, ratio_q, phase_clr, phase_done;
  logic [TW-1:0] dur;

  dial_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .digit_valid_i(digit_valid_i),
    .digit_i      (digit_i),
    .rate_20_i    (rate_20_i),
    .ratio_40_i   (ratio_40_i),
    .on_hook_i    (on_hook_i),
    .phase_done_i (phase_done),
    .state_o      (state),
    .rate_q_o     (rate_q),
    .ratio_q_o    (ratio_q),
    .phase_clr_o  (phase_clr),
    .dp_o         (dp_o),
    .busy_o       (busy_o),
    .hp_mute_o    (hp_mute_o),
    .tp_mute_no   (tp_mute_no)
  );

  dial_timing #(
    .TW(TW),
    .MK_10_40(MK_10_40), .BK_10_40(BK_10_40),
    .MK_10_33(MK_10_33), .BK_10_33(BK_10_33),
    .MK_20_40(MK_20_40), .BK_20_40(BK_20_40),
    .MK_20_33(MK_20_33), .BK_20_33(BK_20_33),
    .IDP_10(IDP_10), .IDP_20(IDP_20)
  ) u_timing (
    .state_i   (state),
    .rate_20_i (rate_q),
    .ratio_40_i(ratio_q),
    .dur_o     (dur)
  );

  dial_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(phase_clr),
    .tick_i (tick_ms_i),
    .dur_i  (dur),
    .done_o (phase_done)
  );

endmodule

// File: tb/pulse_dialer_bench.sv
module pulse_dialer_bench;

  localparam int P = 4;  // clock cycles per millisecond tick

  typedef struct {
    byte   kind;   // P pre, B break, M make, I interdigit
    int    len;
    string req;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_ms_i;
  logic       digit_valid_i = 1'b0;
  logic [3:0] digit_i = 4'd0;
  logic       rate_20_i = 1'b0;
  logic       ratio_40_i = 1'b1;
  logic       on_hook_i = 1'b0;
  logic       dp_o, busy_o, hp_mute_o, tp_mute_no;

  logic [1:0] tdiv = 2'd0;
  item_t      exp_q[$];
  int         checks = 0;
  int         failures = 0;
  bit         mon_en = 1'b1;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) tdiv <= tdiv + 2'd1;
  assign tick_ms_i = (tdiv == 2'd0);

  pulse_dialer u_pulse_dialer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_ms_i(tick_ms_i),
    .digit_valid_i(digit_valid_i), .digit_i(digit_i),
    .rate_20_i(rate_20_i), .ratio_40_i(ratio_40_i), .on_hook_i(on_hook_i),
    .dp_o(dp_o), .busy_o(busy_o), .hp_mute_o(hp_mute_o), .tp_mute_no(tp_mute_no)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures each interval in ticks and compares with the queue.
  task automatic take(input byte kind, input int cyc);
    item_t it;
    int    len;
    len = (cyc + P - 1) / P;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2", "unexpected interval", int'(kind), 0);
    end else begin
      it = exp_q.pop_front();
      chk(it.kind == kind, it.req, "interval kind", int'(kind), int'(it.kind));
      chk(it.len == len, it.req, "interval ticks", len, it.len);
    end
  endtask

  bit prev_dp = 1'b0, prev_busy = 1'b0, first = 1'b0;
  int cyc = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (busy_o && !prev_busy) begin
        cyc = 0;
        first = 1'b1;
      end
      if (dp_o && !prev_dp) begin
        if (mon_en) begin
          take(first ? "P" : "M", cyc);
          chk(hp_mute_o == 1'b1, "R9", "hp_mute during break", int'(hp_mute_o), 1);
          chk(tp_mute_no == 1'b0, "R10", "tp_mute_no during break", int'(tp_mute_no), 0);
        end
        first = 1'b0;
        cyc = 0;
      end
      if (!dp_o && prev_dp) begin
        if (mon_en) begin
          take("B", cyc);
          if (exp_q.size() != 0 && exp_q[0].kind == "I")
            chk(hp_mute_o == 1'b0, "R9", "hp_mute in interdigit pause", int'(hp_mute_o), 0);
        end
        cyc = 0;
      end
      if (!busy_o && prev_busy) begin
        if (mon_en) begin
          take("I", cyc);
          chk(tp_mute_no == 1'b1, "R10", "tp_mute_no after digit", int'(tp_mute_no), 1);
          chk(hp_mute_o == 1'b0, "R9", "hp_mute after digit", int'(hp_mute_o), 0);
        end
        cyc = 0;
      end
      prev_dp   = dp_o;
      prev_busy = busy_o;
    end
  end

  // Driver: queue the expected intervals, then strobe the digit.
  task automatic start_digit(input int d, input bit r20, input bit r40, input string req);
    int n, mk, bk, idp;
    n   = (d == 0) ? 10 : d;
    mk  = r20 ? (r40 ? 20 : 17) : (r40 ? 40 : 33);
    bk  = r20 ? (r40 ? 30 : 33) : (r40 ? 60 : 67);
    idp = r20 ? 500 : 800;
    exp_q.push_back('{kind: "P", len: mk, req: req});
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{kind: "B", len: bk, req: req});
      if (i != n - 1) exp_q.push_back('{kind: "M", len: mk, req: req});
    end
    exp_q.push_back('{kind: "I", len: idp, req: req});
    @(negedge clk_i);
    rate_20_i     = r20;
    ratio_40_i    = r40;
    digit_i       = 4'(d);
    digit_valid_i = 1'b1;
    @(negedge clk_i);
    digit_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic strobe(input int d);
    @(negedge clk_i);
    digit_i       = 4'(d);
    digit_valid_i = 1'b1;
    @(negedge clk_i);
    digit_valid_i = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    chk(dp_o == 1'b0, "R1", "dp_o at reset", int'(dp_o), 0);
    chk(busy_o == 1'b0, "R1", "busy_o at reset", int'(busy_o), 0);
    chk(hp_mute_o == 1'b0, "R1", "hp_mute_o at reset", int'(hp_mute_o), 0);
    chk(tp_mute_no == 1'b1, "R1", "tp_mute_no at reset", int'(tp_mute_no), 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R3 R6 R7: three pulses, 10 pps, 40:60
    start_digit(3, 1'b0, 1'b1, "R3");
    wait_idle();
    // R2 R5: code 0 gives ten pulses, 20 pps, 33:67
    start_digit(0, 1'b1, 1'b0, "R2");
    wait_idle();
    // R4: 10 pps, 33:67
    start_digit(2, 1'b0, 1'b0, "R4");
    wait_idle();
    // R5 R7: 20 pps, 40:60, 500 ms interdigit
    start_digit(1, 1'b1, 1'b1, "R5");
    wait_idle();

    // R2: codes above 9 are ignored
    strobe(12);
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0, "R2", "busy_o after code 12", int'(busy_o), 0);
    strobe(15);
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0, "R2", "busy_o after code 15", int'(busy_o), 0);

    // R8: second strobe while busy is dropped
    start_digit(2, 1'b0, 1'b1, "R8");
    repeat (200) @(negedge clk_i);
    strobe(5);
    wait_idle();
    chk(exp_q.size() == 0, "R8", "items left after busy strobe", exp_q.size(), 0);
    repeat (20) @(negedge clk_i);
    chk(busy_o == 1'b0, "R8", "busy_o after ignored strobe", int'(busy_o), 0);

    // R12: selects flipped mid-digit do not alter it
    start_digit(2, 1'b0, 1'b1, "R12");
    while (!dp_o) @(negedge clk_i);
    rate_20_i  = 1'b1;
    ratio_40_i = 1'b0;
    wait_idle();

    // R11: on-hook in the middle of a break
    mon_en = 1'b0;
    start_digit(5, 1'b0, 1'b1, "R11");
    while (!dp_o) @(negedge clk_i);
    repeat (10) @(negedge clk_i);
    on_hook_i = 1'b1;
    @(negedge clk_i);
    chk(dp_o == 1'b0, "R11", "dp_o after on-hook", int'(dp_o), 0);
    chk(busy_o == 1'b0, "R11", "busy_o after on-hook", int'(busy_o), 0);
    chk(hp_mute_o == 1'b0, "R11", "hp_mute_o after on-hook", int'(hp_mute_o), 0);
    chk(tp_mute_no == 1'b1, "R11", "tp_mute_no after on-hook", int'(tp_mute_no), 1);
    exp_q.delete();
    strobe(4);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 1'b0, "R11", "strobe while on-hook", int'(busy_o), 0);
    on_hook_i = 1'b0;
    repeat (5) @(negedge clk_i);
    mon_en = 1'b1;
    start_digit(1, 1'b0, 1'b1, "R11");
    wait_idle();

    chk(exp_q.size() == 0, "R2", "expected intervals not seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(negedge clk_i);
      n++;
    end
    if (!done) chk(1'b0, "R1", "watchdog expired", n, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule